// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Unit

This unit sits between a two-wide issue stage and four execution pipes. Each cycle it looks at up to two decoded instructions, one per issue slot. It decides which pipe entry, or entries, each instruction claims. The four pipes are a complex-integer pipe (I), a simple-integer pipe (J), a memory pipe (L) and a floating-point pipe (F). Every pipe has exactly one dispatch entry per cycle. The unit checks each instruction's class against what every pipe can execute and against the rules on which slot it may issue from. It also checks the busy state each pipe reports.

The issue slots use a valid/ready handshake. A slot's ready is high, in the same cycle, only when its instruction has been given every pipe entry it needs. The chosen entries are registered. One cycle after acceptance, each claimed pipe sees a valid pulse, the instruction's payload and a bit naming the slot it came from. Slot 0 holds the older instruction, so slot 1 never goes ahead of it.

Top module: `pipe_steer`

## Requirements
- R1: While rst_n is low, both ready outputs are 0. In the cycle after any clock edge at which rst_n was low, pipe_valid is 0.
- R2: A simple-integer instruction (class code 0) goes to the I pipe (pipe_valid bit 0) when I is not busy. When I is busy it goes to the J pipe (bit 1). It stalls when both are busy.
- R3: When both slots hold instructions that can use an integer pipe and neither pipe is busy, slot 0 gets I and slot 1 gets J. This covers a simple op in slot 1 behind a simple op or a complex op (class 1) in slot 0. pipe_src bit 1 is then 1, meaning slot 1.
- R4: A complex-integer instruction (code 1) uses only I. A memory instruction (code 2) uses only L (bit 2). A floating-point instruction (code 3) uses only F (bit 3).
- R5: A reserve/conditional atomic (code 4) is accepted only from slot 0. It needs both I and L to be free, and it claims both in the same cycle. An atomic in slot 1 is never accepted.
- R6: A synchronize instruction (code 5) needs all four pipes free and claims all four entries together.
- R7: When both slots need the same single-choice pipe, slot 0 gets it and slot 1 stalls. No pipe entry is claimed by both slots in one cycle.
- R8: Slot 1 is accepted only in a cycle where slot 0 is valid and accepted.
- R9: No instruction is steered to a pipe whose pipe_busy bit is high in the accepting cycle.
- R10: An accepted instruction appears on its pipes' pipe_valid, pipe_src (0 = slot 0, 1 = slot 1) and pipe_data one cycle after acceptance. A pipe with no accepted instruction shows pipe_valid 0 in the next cycle.
- R11: Reserved class codes 6 and 7 are steered like a complex-integer instruction (I only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_class | input | 3 | Slot 0 instruction class code |
| s0_data | input | DATA_W | Slot 0 payload |
| s0_ready | output | 1 | Slot 0 accepted this cycle |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_class | input | 3 | Slot 1 instruction class code |
| s1_data | input | DATA_W | Slot 1 payload |
| s1_ready | output | 1 | Slot 1 accepted this cycle |
| pipe_busy | input | 4 | Per-pipe busy; bit 0 I, 1 J, 2 L, 3 F |
| pipe_valid | output | 4 | Registered dispatch pulse per pipe |
| pipe_src | output | 4 | Per pipe: 1 when the entry came from slot 1 |
| pipe_data | output | 4×DATA_W | Registered payload per pipe |

## Verification
The hardest case to reach is slot 1's placement when it depends on where slot 0 was pushed. One example is a simple op in slot 0 diverted to J because I is busy, which then leaves no integer pipe for a simple op in slot 1. Another is a complex op in slot 0 taking I while a simple op behind it falls through to J. The stimulus table pairs each class in slot 1 with different slot 0 classes under partial busy masks. This makes the second slot's choice depend on the first. Directed steps then check the one-cycle output pulse and a reset applied while an instruction is waiting.

// File: rtl/steer_pkg.sv
package steer_pkg;
   localparam int NPIPE   = 4;
   localparam int CLS_W   = 3;
   localparam int P_I     = 0;
   localparam int P_J     = 1;
   localparam int P_L     = 2;
   localparam int P_F     = 3;

   localparam logic [CLS_W-1:0] C_FLEX = 3'd0;
   localparam logic [CLS_W-1:0] C_CPLX = 3'd1;
   localparam logic [CLS_W-1:0] C_MEM  = 3'd2;
   localparam logic [CLS_W-1:0] C_FLT  = 3'd3;
   localparam logic [CLS_W-1:0] C_PAIR = 3'd4;
   localparam logic [CLS_W-1:0] C_SYNC = 3'd5;

   // Pipe entries a fixed-placement class must hold together; the
   // flexible class returns zero and is placed by the slot picker.
   function automatic logic [NPIPE-1:0] fixed_need(input logic [CLS_W-1:0] c);
      logic [NPIPE-1:0] m;
      m = '0;
      case (c)
         C_FLEX: m = '0;
         C_MEM:  m[P_L] = 1'b1;
         C_FLT:  m[P_F] = 1'b1;
         C_PAIR: begin m[P_I] = 1'b1; m[P_L] = 1'b1; end
         C_SYNC: m = '1;
         default: m[P_I] = 1'b1;   // complex and reserved codes (R11)
      endcase
      return m;
   endfunction
endpackage

// File: rtl/steer_slot.sv
module steer_slot
   import steer_pkg::*;
#(
   parameter bit ALLOW_PAIR  = 1'b1,
   parameter bit FLEX_J_FIRST = 1'b0
) (
   input  logic             en,
   input  logic [CLS_W-1:0] cls,
   input  logic [NPIPE-1:0] avail,
   output logic [NPIPE-1:0] grant,
   output logic             ok
);
   localparam int FIRST  = FLEX_J_FIRST ? P_J : P_I;
   localparam int SECOND = FLEX_J_FIRST ? P_I : P_J;

   logic [NPIPE-1:0] need;

   always_comb begin
      need  = fixed_need(cls);
      grant = '0;
      ok    = 1'b0;
      if (en) begin
         if (cls == C_FLEX) begin
            if (avail[FIRST])       grant[FIRST]  = 1'b1;
            else if (avail[SECOND]) grant[SECOND] = 1'b1;
            ok = |grant;
         end else if (cls == C_PAIR && !ALLOW_PAIR) begin
            ok = 1'b0;
         end else if ((need & ~avail) == '0) begin
            grant = need;
            ok    = 1'b1;
         end
      end
   end

   // R9: nothing granted that was not offered
   always_comb begin
      p_grant_free_r9: assert ((grant & ~avail) == '0)
         else $error("grant to unavailable pipe");
   end
endmodule

// File: rtl/steer_entry.sv
module steer_entry #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take0,
   input  logic              take1,
   input  logic [DATA_W-1:0] d0,
   input  logic [DATA_W-1:0] d1,
   output logic              valid_q,
   output logic              src_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         src_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= take0 | take1;
         if (take0 | take1) begin
            src_q  <= take1;
            data_q <= take1 ? d1 : d0;
         end
      end
   end

   // R10: a valid entry was taken on the previous edge
   p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $past(take0 | take1))
      else $error("entry valid without a take");
   // R7: one source per entry per cycle
   p_one_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(take0 && take1))
      else $error("entry taken by both slots");
endmodule

// File: rtl/pipe_steer.sv
module pipe_steer
   import steer_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit FLEX_J_FIRST = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         s0_valid,
   input  logic [2:0]                   s0_class,
   input  logic [DATA_W-1:0]            s0_data,
   output logic                         s0_ready,
   input  logic                         s1_valid,
   input  logic [2:0]                   s1_class,
   input  logic [DATA_W-1:0]            s1_data,
   output logic                         s1_ready,
   input  logic [3:0]                   pipe_busy,
   output logic [3:0]                   pipe_valid,
   output logic [3:0]                   pipe_src,
   output logic [3:0][DATA_W-1:0]       pipe_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (NPIPE != 4 || CLS_W != 3) begin : g_bad_pkg
      $error("port widths assume four pipes and 3-bit classes");
   end

   logic [NPIPE-1:0] grant0, grant1, avail0, avail1;
   logic             ok0, ok1, en0, en1;

   assign en0    = rst_n & s0_valid;
   assign avail0 = ~pipe_busy;

   steer_slot #(.ALLOW_PAIR(1'b1), .FLEX_J_FIRST(FLEX_J_FIRST)) u_slot0 (
      .en(en0), .cls(s0_class), .avail(avail0), .grant(grant0), .ok(ok0));

   // Slot 1 is younger: it only competes once slot 0 has been placed.
   assign en1    = rst_n & s1_valid & ok0;
   assign avail1 = ~pipe_busy & ~grant0;

   steer_slot #(.ALLOW_PAIR(1'b0), .FLEX_J_FIRST(FLEX_J_FIRST)) u_slot1 (
      .en(en1), .cls(s1_class), .avail(avail1), .grant(grant1), .ok(ok1));

   assign s0_ready = ok0;
   assign s1_ready = ok1;

   for (genvar p = 0; p < NPIPE; p++) begin : g_entry
      steer_entry #(.DATA_W(DATA_W)) u_ent (
         .clk(clk), .rst_n(rst_n),
         .take0(grant0[p]), .take1(grant1[p]),
         .d0(s0_data), .d1(s1_data),
         .valid_q(pipe_valid[p]), .src_q(pipe_src[p]), .data_q(pipe_data[p]));
   end

   // R8: younger slot never overtakes the older one
   p_inorder_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s1_ready |-> s0_ready)
      else $error("slot 1 accepted ahead of slot 0");
   // R5: an atomic in slot 1 is held
   p_pair_slot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_class == C_PAIR) |-> !s1_ready)
      else $error("atomic accepted from slot 1");
   // R5: atomic claims I and L together
   p_pair_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_ready && s0_class == C_PAIR) |=> (pipe_valid[P_I] && pipe_valid[P_L]))
      else $error("atomic missing an entry");
   // R6: synchronize claims every entry
   p_sync_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_ready && s0_class == C_SYNC) |=> (pipe_valid == 4'hF))
      else $error("synchronize missing an entry");
   // R9: no dispatch into a pipe busy at acceptance
   p_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_valid & $past(pipe_busy)) == 4'h0)
      else $error("dispatch to busy pipe");
endmodule

// File: tb/sim_pipe_steer.sv
`timescale 1ns/1ps
module sim_pipe_steer;
   localparam int DW = 32;
   localparam int NV = 25;
   // {req[25:22], v0, c0[2:0], v1, c1[2:0], busy[3:0], r0, r1, pv[3:0], src[3:0]}
   localparam logic [NV-1:0][25:0] VEC = '{
      {4'd2,  1'b1,3'd0, 1'b0,3'd0, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R2 flex to I
      {4'd2,  1'b1,3'd0, 1'b0,3'd0, 4'b0001, 1'b1,1'b0, 4'b0010, 4'b0000}, // R2 flex to J
      {4'd2,  1'b1,3'd0, 1'b0,3'd0, 4'b0011, 1'b0,1'b0, 4'b0000, 4'b0000}, // R2 stall
      {4'd3,  1'b1,3'd0, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0011, 4'b0010}, // R3 pair of flex
      {4'd9,  1'b1,3'd0, 1'b1,3'd0, 4'b0001, 1'b1,1'b0, 4'b0010, 4'b0000}, // R9 slot0 to J
      {4'd4,  1'b1,3'd1, 1'b0,3'd0, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R4 complex
      {4'd4,  1'b1,3'd2, 1'b0,3'd0, 4'b0000, 1'b1,1'b0, 4'b0100, 4'b0000}, // R4 memory
      {4'd4,  1'b1,3'd3, 1'b0,3'd0, 4'b0000, 1'b1,1'b0, 4'b1000, 4'b0000}, // R4 float
      {4'd4,  1'b1,3'd1, 1'b1,3'd2, 4'b0000, 1'b1,1'b1, 4'b0101, 4'b0100}, // R4 complex+mem
      {4'd7,  1'b1,3'd2, 1'b1,3'd2, 4'b0000, 1'b1,1'b0, 4'b0100, 4'b0000}, // R7 mem conflict
      {4'd8,  1'b1,3'd3, 1'b1,3'd3, 4'b1000, 1'b0,1'b0, 4'b0000, 4'b0000}, // R8 stalled slot0
      {4'd8,  1'b0,3'd0, 1'b1,3'd0, 4'b0000, 1'b0,1'b0, 4'b0000, 4'b0000}, // R8 empty slot0
      {4'd5,  1'b1,3'd4, 1'b0,3'd0, 4'b0000, 1'b1,1'b0, 4'b0101, 4'b0000}, // R5 atomic
      {4'd5,  1'b1,3'd4, 1'b0,3'd0, 4'b0100, 1'b0,1'b0, 4'b0000, 4'b0000}, // R5 L busy
      {4'd5,  1'b1,3'd3, 1'b1,3'd4, 4'b0000, 1'b1,1'b0, 4'b1000, 4'b0000}, // R5 slot1 atomic
      {4'd5,  1'b1,3'd4, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0111, 4'b0010}, // R5 atomic+flex
      {4'd6,  1'b1,3'd5, 1'b0,3'd0, 4'b0000, 1'b1,1'b0, 4'b1111, 4'b0000}, // R6 sync
      {4'd6,  1'b1,3'd5, 1'b0,3'd0, 4'b0010, 1'b0,1'b0, 4'b0000, 4'b0000}, // R6 J busy
      {4'd6,  1'b1,3'd0, 1'b1,3'd5, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R6 slot1 sync
      {4'd11, 1'b1,3'd6, 1'b0,3'd0, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R11 code 6
      {4'd11, 1'b1,3'd7, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0011, 4'b0010}, // R11 code 7
      {4'd7,  1'b1,3'd1, 1'b1,3'd1, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R7 I conflict
      {4'd7,  1'b1,3'd0, 1'b1,3'd1, 4'b0000, 1'b1,1'b0, 4'b0001, 4'b0000}, // R7 flex holds I
      {4'd3,  1'b1,3'd1, 1'b1,3'd0, 4'b0000, 1'b1,1'b1, 4'b0011, 4'b0010}, // R3 complex+flex
      {4'd9,  1'b1,3'd0, 1'b1,3'd0, 4'b0010, 1'b1,1'b0, 4'b0001, 4'b0000}  // R9 J busy
   };

   logic clk = 1'b0, rst_n;
   logic s0_valid, s1_valid, s0_ready, s1_ready;
   logic [2:0] s0_class, s1_class;
   logic [DW-1:0] s0_data, s1_data;
   logic [3:0] pipe_busy, pipe_valid, pipe_src;
   logic [3:0][DW-1:0] pipe_data;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   pipe_steer #(.DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .s0_valid(s0_valid), .s0_class(s0_class), .s0_data(s0_data), .s0_ready(s0_ready),
      .s1_valid(s1_valid), .s1_class(s1_class), .s1_data(s1_data), .s1_ready(s1_ready),
      .pipe_busy(pipe_busy), .pipe_valid(pipe_valid), .pipe_src(pipe_src),
      .pipe_data(pipe_data));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   initial begin
      #(20.0 * 200000);
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; s0_valid = 1'b1; s0_class = 3'd0; s0_data = '0;
      s1_valid = 1'b1; s1_class = 3'd0; s1_data = '0; pipe_busy = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset s0_ready", 32'(s0_ready), 0);
      chk("R1 reset s1_ready", 32'(s1_ready), 0);
      chk("R1 reset pipe_valid", 32'(pipe_valid), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         string t;
         v = VEC[NV-1-i];
         t = $sformatf("R%0d vec%0d", v[25:22], i);
         s0_valid = v[21]; s0_class = v[20:18];
         s1_valid = v[17]; s1_class = v[16:14];
         pipe_busy = v[13:10];
         s0_data = 32'hA000_0000 + i; s1_data = 32'hB000_0000 + i;
         #2;
         chk({t, " s0_ready"}, 32'(s0_ready), 32'(v[9]));
         chk({t, " s1_ready"}, 32'(s1_ready), 32'(v[8]));
         @(posedge clk); #2;
         chk({t, " pipe_valid"}, 32'(pipe_valid), 32'(v[7:4]));
         chk({t, " pipe_src"}, 32'(pipe_src & v[7:4]), 32'(v[3:0]));
         for (int p = 0; p < 4; p++)
            if (v[4+p])
               chk({t, $sformatf(" data p%0d", p)}, pipe_data[p],
                   v[p] ? 32'hB000_0000 + i : 32'hA000_0000 + i);
         @(negedge clk);
      end

      // R10: one-cycle pulse, then idle
      s0_valid = 1'b1; s0_class = 3'd3; s1_valid = 1'b0; pipe_busy = '0;
      s0_data = 32'h1234_5678;
      @(posedge clk); #2;
      chk("R10 float pulse", 32'(pipe_valid), 32'h8);
      chk("R10 float data", pipe_data[3], 32'h1234_5678);
      @(negedge clk);
      s0_valid = 1'b0;
      @(posedge clk); #2;
      chk("R10 idle after pulse", 32'(pipe_valid), 0);
      @(negedge clk);

      // R1: reset while an instruction waits
      s0_valid = 1'b1; s0_class = 3'd0; rst_n = 1'b0;
      #2;
      chk("R1 midrun s0_ready", 32'(s0_ready), 0);
      @(posedge clk); #2;
      chk("R1 midrun pipe_valid", 32'(pipe_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk("R2 after reset ready", 32'(s0_ready), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule